// File: doc/BRIEF.md
# Tiled Cross-Correlation Engine with Long-Term Accumulation

This block forms, for every frequency channel, the complex cross-products of all signal pairs and sums them over an integration. Samples for one channel arrive on a valid/ready input stream, ordered by signal and then by time. They are stored in a local sample memory. A fixed ARR x ARR array of complex multiply-accumulate cells then sweeps the upper triangle of the NSIG x NSIG pair matrix, one tile at a time. Every tile replays TLEN stored time samples, so the same stored data serve many more pairs than the array has cells.

Each tile's short-integration sums are added into a long-term accumulator memory that holds one entry per channel and pair. The first short integration of a long integration overwrites the stored value instead of adding to it. After the NLTA-th short integration, the accumulated results of each tile are streamed out. Each result carries its pair indices and its channel number. Upstream logic delivers complete short-integration frames, channel by channel. Downstream logic takes a plain list of results through a valid/ready handshake.

Back-pressure works as follows. `in_ready` is high only while a channel's samples are being collected, and a sample is taken on a clock edge where both `in_valid` and `in_ready` are high. While `out_valid` is high and `out_ready` is low, the block stalls and holds every output field stable. No result is dropped or repeated.

Top module: `xcorr_xengine`

## Requirements
- R1: Input order is channel, then signal, then time. Within a channel, the k-th accepted sample belongs to signal k / TLEN at time k % TLEN. `in_ready` stays high while a channel is being loaded and goes low on the cycle after that channel's last sample is accepted.
- R2: Each result is the sum, over TLEN samples and NLTA short integrations, of x_a times conj(x_b). The real part adds ar*br + ai*bi, and the imaginary part adds ai*br - ar*bi. An autocorrelation always has a zero imaginary part.
- R3: Samples are signed 4-bit two's complement. With every sample equal to -8-8j, each result is exactly 128*TLEN*NLTA + 0j, with no wraparound.
- R4: Only pairs with a <= b are emitted, and autocorrelations are included. That gives exactly NSIG*(NSIG+1)/2 results per channel per long integration.
- R5: Results leave in ascending channel order. Within a channel, tiles are visited by tile row ascending and then by tile column from the diagonal upward. Within a tile, entries go row-major, so a = tile_row*ARR + r and b = tile_col*ARR + c.
- R6: No result is emitted during the first NLTA-1 short integrations of a long integration.
- R7: The first short integration of every long integration overwrites the long-term accumulator, so a long integration's results depend only on its own samples.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and all output fields keep their values on the next cycle.
- R9: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block accepts a sample |
| in_re | input | SW | Sample real part, signed |
| in_im | input | SW | Sample imaginary part, signed |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts result |
| out_re | output | LACCW | Accumulated real part, signed |
| out_im | output | LACCW | Accumulated imaginary part, signed |
| out_sig_a | output | SIGW | First signal index of the pair |
| out_sig_b | output | SIGW | Second signal index of the pair |
| out_chan | output | CHW | Channel index |

## Verification
The hardest case to reach from the ports is a stall on the diagonal tiles. There the entries with a > b are skipped silently, while a held result must stay frozen across random `out_ready` gaps that coincide with those skips. The bench reaches it by running full long integrations with random input gaps and random output back-pressure. It then compares every streamed result, in order, against sums it computes itself. A second long integration with fresh data shows that the accumulator was overwritten, and an all-minus-eight run drives every accumulator to its extreme value.

// File: rtl/xcorr_pkg.sv
package xcorr_pkg;
  typedef enum logic [2:0] {
    ST_LOAD,
    ST_MAC,
    ST_COMMIT,
    ST_DRAIN,
    ST_NEXT
  } xc_state_t;
endpackage

// File: rtl/xcorr_smem.sv
module xcorr_smem #(
  parameter int SW   = 4,
  parameter int NSIG = 8,
  parameter int TLEN = 4,
  parameter int ARR  = 2,
  parameter int TIW  = 2,
  parameter int TW   = 2,
  localparam int DEPTH = NSIG * TLEN,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic signed [SW-1:0] wr_re,
  input  logic signed [SW-1:0] wr_im,
  input  logic [TIW-1:0]       row_tile,
  input  logic [TIW-1:0]       col_tile,
  input  logic [TW-1:0]        t_idx,
  output logic signed [SW-1:0] row_re [ARR],
  output logic signed [SW-1:0] row_im [ARR],
  output logic signed [SW-1:0] col_re [ARR],
  output logic signed [SW-1:0] col_im [ARR]
);
  logic signed [SW-1:0] m_re [DEPTH];
  logic signed [SW-1:0] m_im [DEPTH];
  logic [AW-1:0] ra [ARR];
  logic [AW-1:0] ca [ARR];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      m_re[wr_addr] <= wr_re;
      m_im[wr_addr] <= wr_im;
    end
  end

  always_comb begin
    for (int r = 0; r < ARR; r++) begin
      ra[r] = AW'((int'(row_tile) * ARR + r) * TLEN + int'(t_idx));
      ca[r] = AW'((int'(col_tile) * ARR + r) * TLEN + int'(t_idx));
    end
  end

  always_comb begin
    for (int r = 0; r < ARR; r++) begin
      row_re[r] = m_re[ra[r]];
      row_im[r] = m_im[ra[r]];
      col_re[r] = m_re[ca[r]];
      col_im[r] = m_im[ca[r]];
    end
  end
endmodule

// File: rtl/xcorr_cmac.sv
module xcorr_cmac #(
  parameter int SW   = 4,
  parameter int ACCW = 11,
  localparam int PW  = 2 * SW + 1
) (
  input  logic                   clk,
  input  logic                   en,
  input  logic                   first,
  input  logic signed [SW-1:0]   a_re,
  input  logic signed [SW-1:0]   a_im,
  input  logic signed [SW-1:0]   b_re,
  input  logic signed [SW-1:0]   b_im,
  output logic signed [ACCW-1:0] acc_re,
  output logic signed [ACCW-1:0] acc_im
);
  logic signed [PW-1:0] xa_re, xa_im, xb_re, xb_im;
  logic signed [PW-1:0] p_re, p_im;

  assign xa_re = $signed({{(PW-SW){a_re[SW-1]}}, a_re});
  assign xa_im = $signed({{(PW-SW){a_im[SW-1]}}, a_im});
  assign xb_re = $signed({{(PW-SW){b_re[SW-1]}}, b_re});
  assign xb_im = $signed({{(PW-SW){b_im[SW-1]}}, b_im});

  // a times the conjugate of b
  assign p_re = xa_re * xb_re + xa_im * xb_im;
  assign p_im = xa_im * xb_re - xa_re * xb_im;

  always_ff @(posedge clk) begin
    if (en) begin
      acc_re <= first ? ACCW'(p_re) : acc_re + ACCW'(p_re);
      acc_im <= first ? ACCW'(p_im) : acc_im + ACCW'(p_im);
    end
  end
endmodule

// File: rtl/xcorr_cmac_array.sv
module xcorr_cmac_array #(
  parameter int SW   = 4,
  parameter int ACCW = 11,
  parameter int ARR  = 2,
  localparam int NN  = ARR * ARR
) (
  input  logic                   clk,
  input  logic                   en,
  input  logic                   first,
  input  logic signed [SW-1:0]   row_re [ARR],
  input  logic signed [SW-1:0]   row_im [ARR],
  input  logic signed [SW-1:0]   col_re [ARR],
  input  logic signed [SW-1:0]   col_im [ARR],
  output logic signed [ACCW-1:0] acc_re [NN],
  output logic signed [ACCW-1:0] acc_im [NN]
);
  for (genvar r = 0; r < ARR; r++) begin : g_row
    for (genvar c = 0; c < ARR; c++) begin : g_col
      xcorr_cmac #(.SW(SW), .ACCW(ACCW)) u_cell (
        .clk    (clk),
        .en     (en),
        .first  (first),
        .a_re   (row_re[r]),
        .a_im   (row_im[r]),
        .b_re   (col_re[c]),
        .b_im   (col_im[c]),
        .acc_re (acc_re[r*ARR+c]),
        .acc_im (acc_im[r*ARR+c])
      );
    end
  end
endmodule

// File: rtl/xcorr_lta.sv
module xcorr_lta #(
  parameter int ACCW  = 11,
  parameter int LACCW = 14,
  parameter int NN    = 4,
  parameter int DEPTH = 80,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic                    overwrite,
  input  logic [AW-1:0]           base,
  input  logic signed [ACCW-1:0]  in_re [NN],
  input  logic signed [ACCW-1:0]  in_im [NN],
  input  logic [AW-1:0]           rd_addr,
  output logic signed [LACCW-1:0] rd_re,
  output logic signed [LACCW-1:0] rd_im
);
  logic signed [LACCW-1:0] l_re [DEPTH];
  logic signed [LACCW-1:0] l_im [DEPTH];
  logic [AW-1:0] wa [NN];

  always_comb begin
    for (int k = 0; k < NN; k++) wa[k] = base + AW'(k);
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int k = 0; k < NN; k++) begin
        l_re[wa[k]] <= overwrite ? LACCW'(in_re[k]) : l_re[wa[k]] + LACCW'(in_re[k]);
        l_im[wa[k]] <= overwrite ? LACCW'(in_im[k]) : l_im[wa[k]] + LACCW'(in_im[k]);
      end
    end
  end

  assign rd_re = l_re[rd_addr];
  assign rd_im = l_im[rd_addr];
endmodule

// File: rtl/xcorr_xengine.sv
module xcorr_xengine
  import xcorr_pkg::*;
#(
  parameter int SW   = 4,
  parameter int NSIG = 8,
  parameter int ARR  = 2,
  parameter int TLEN = 4,
  parameter int NCH  = 2,
  parameter int NLTA = 3,
  localparam int ACCW  = 2 * SW + 1 + $clog2(TLEN),
  localparam int LACCW = ACCW + $clog2(NLTA) + 1,
  localparam int SIGW  = (NSIG > 1) ? $clog2(NSIG) : 1,
  localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [SW-1:0]    in_re,
  input  logic signed [SW-1:0]    in_im,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [LACCW-1:0] out_re,
  output logic signed [LACCW-1:0] out_im,
  output logic [SIGW-1:0]         out_sig_a,
  output logic [SIGW-1:0]         out_sig_b,
  output logic [CHW-1:0]          out_chan
);
  localparam int NT     = NSIG / ARR;
  localparam int NTT    = NT * (NT + 1) / 2;
  localparam int NN     = ARR * ARR;
  localparam int SMD    = NSIG * TLEN;
  localparam int SAW    = (SMD > 1) ? $clog2(SMD) : 1;
  localparam int LDEPTH = NCH * NTT * NN;
  localparam int LAW    = (LDEPTH > 1) ? $clog2(LDEPTH) : 1;
  localparam int TIW    = (NT > 1) ? $clog2(NT) : 1;
  localparam int TCW    = (NTT > 1) ? $clog2(NTT) : 1;
  localparam int TW     = (TLEN > 1) ? $clog2(TLEN) : 1;
  localparam int EW     = (NN > 1) ? $clog2(NN) : 1;
  localparam int FW     = (NLTA > 1) ? $clog2(NLTA) : 1;

  xc_state_t         state;
  logic [SAW-1:0]    ld_cnt;
  logic [TW-1:0]     t_cnt;
  logic [TIW-1:0]    ti, tj;
  logic [TCW-1:0]    tcnt;
  logic [EW-1:0]     e_cnt;
  logic [CHW-1:0]    chan;
  logic [FW-1:0]     frame;

  logic signed [SW-1:0]   row_re [ARR];
  logic signed [SW-1:0]   row_im [ARR];
  logic signed [SW-1:0]   col_re [ARR];
  logic signed [SW-1:0]   col_im [ARR];
  logic signed [ACCW-1:0] acc_re [NN];
  logic signed [ACCW-1:0] acc_im [NN];

  logic            mac_en, mac_first, lta_wr, lta_over, pair_ok, step;
  logic [LAW-1:0]  lta_base, lta_rd;
  int              pa, pb, lb;

  assign in_ready  = (state == ST_LOAD);
  assign mac_en    = (state == ST_MAC);
  assign mac_first = (t_cnt == '0);
  assign lta_wr    = (state == ST_COMMIT);
  assign lta_over  = (frame == '0);

  // pair decode for the entry being drained
  always_comb begin
    pa = int'(ti) * ARR + int'(e_cnt) / ARR;
    pb = int'(tj) * ARR + int'(e_cnt) % ARR;
    lb = (int'(chan) * NTT + int'(tcnt)) * NN;
    pair_ok  = (pa <= pb);
    lta_base = LAW'(lb);
    lta_rd   = LAW'(lb + int'(e_cnt));
  end

  assign out_valid = (state == ST_DRAIN) && pair_ok;
  assign step      = !out_valid || out_ready;
  assign out_sig_a = SIGW'(pa);
  assign out_sig_b = SIGW'(pb);
  assign out_chan  = chan;

  xcorr_smem #(.SW(SW), .NSIG(NSIG), .TLEN(TLEN), .ARR(ARR), .TIW(TIW), .TW(TW)) u_smem (
    .clk      (clk),
    .wr_en    (in_valid && in_ready),
    .wr_addr  (ld_cnt),
    .wr_re    (in_re),
    .wr_im    (in_im),
    .row_tile (ti),
    .col_tile (tj),
    .t_idx    (t_cnt),
    .row_re   (row_re),
    .row_im   (row_im),
    .col_re   (col_re),
    .col_im   (col_im)
  );

  xcorr_cmac_array #(.SW(SW), .ACCW(ACCW), .ARR(ARR)) u_array (
    .clk    (clk),
    .en     (mac_en),
    .first  (mac_first),
    .row_re (row_re),
    .row_im (row_im),
    .col_re (col_re),
    .col_im (col_im),
    .acc_re (acc_re),
    .acc_im (acc_im)
  );

  xcorr_lta #(.ACCW(ACCW), .LACCW(LACCW), .NN(NN), .DEPTH(LDEPTH)) u_lta (
    .clk       (clk),
    .wr_en     (lta_wr),
    .overwrite (lta_over),
    .base      (lta_base),
    .in_re     (acc_re),
    .in_im     (acc_im),
    .rd_addr   (lta_rd),
    .rd_re     (out_re),
    .rd_im     (out_im)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_LOAD;
      ld_cnt <= '0;
      t_cnt  <= '0;
      ti     <= '0;
      tj     <= '0;
      tcnt   <= '0;
      e_cnt  <= '0;
      chan   <= '0;
      frame  <= '0;
    end else begin
      case (state)
        ST_LOAD: begin
          if (in_valid) begin
            if (ld_cnt == SAW'(SMD - 1)) begin
              ld_cnt <= '0;
              t_cnt  <= '0;
              ti     <= '0;
              tj     <= '0;
              tcnt   <= '0;
              state  <= ST_MAC;
            end else begin
              ld_cnt <= ld_cnt + SAW'(1);
            end
          end
        end
        ST_MAC: begin
          if (t_cnt == TW'(TLEN - 1)) state <= ST_COMMIT;
          else t_cnt <= t_cnt + TW'(1);
        end
        ST_COMMIT: begin
          e_cnt <= '0;
          state <= (frame == FW'(NLTA - 1)) ? ST_DRAIN : ST_NEXT;
        end
        ST_DRAIN: begin
          if (step) begin
            if (e_cnt == EW'(NN - 1)) state <= ST_NEXT;
            else e_cnt <= e_cnt + EW'(1);
          end
        end
        ST_NEXT: begin
          t_cnt <= '0;
          tcnt  <= tcnt + TCW'(1);
          state <= ST_MAC;
          if (tj == TIW'(NT - 1)) begin
            if (ti == TIW'(NT - 1)) begin
              state <= ST_LOAD;
              if (chan == CHW'(NCH - 1)) begin
                chan  <= '0;
                frame <= (frame == FW'(NLTA - 1)) ? '0 : frame + FW'(1);
              end else begin
                chan <= chan + CHW'(1);
              end
            end else begin
              ti <= ti + TIW'(1);
              tj <= ti + TIW'(1);
            end
          end else begin
            tj <= tj + TIW'(1);
          end
        end
        default: state <= ST_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/xcorr_xengine_chk.sv
module xcorr_xengine_chk #(
  parameter int SW    = 4,
  parameter int TLEN  = 4,
  parameter int NLTA  = 3,
  parameter int LACCW = 14,
  parameter int SIGW  = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic signed [LACCW-1:0] out_re,
  input logic signed [LACCW-1:0] out_im,
  input logic [SIGW-1:0]         out_sig_a,
  input logic [SIGW-1:0]         out_sig_b
);
  localparam int MAXR = 2 * (1 << (2 * SW - 2)) * TLEN * NLTA;

  // R8: a stalled result stays put
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_re) && $stable(out_im)
      && $stable(out_sig_a) && $stable(out_sig_b));

  // R4: only the upper triangle including the diagonal
  p_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_sig_a <= out_sig_b);

  // R1: input is not taken while results are being streamed
  p_no_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R3: results stay inside the range the sample width allows
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_re <= MAXR) && (out_re >= -MAXR) && (out_im <= MAXR) && (out_im >= -MAXR));

  // R2: autocorrelations are real
  p_auto_real_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_sig_a == out_sig_b) |-> out_im == '0);

  // R9: reset leaves nothing to send
  p_reset_r9: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind xcorr_xengine xcorr_xengine_chk #(
  .SW(SW), .TLEN(TLEN), .NLTA(NLTA), .LACCW(LACCW), .SIGW(SIGW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_re    (out_re),
  .out_im    (out_im),
  .out_sig_a (out_sig_a),
  .out_sig_b (out_sig_b)
);

// File: tb/xcorr_xengine_test.sv
`timescale 1ns/1ps
module xcorr_xengine_test;
  localparam int SW = 4, NSIG = 8, ARR = 2, TLEN = 4, NCH = 2, NLTA = 3;
  localparam int LACCW = 2 * SW + 1 + $clog2(TLEN) + $clog2(NLTA) + 1;
  localparam int NT = NSIG / ARR;
  localparam int NPAIR = NSIG * (NSIG + 1) / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [SW-1:0] in_re = '0, in_im = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic signed [LACCW-1:0] out_re, out_im;
  logic [2:0] out_sig_a, out_sig_b;
  logic [0:0] out_chan;

  always #2 clk = ~clk;

  xcorr_xengine #(.SW(SW), .NSIG(NSIG), .ARR(ARR), .TLEN(TLEN), .NCH(NCH), .NLTA(NLTA)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im), .out_sig_a(out_sig_a), .out_sig_b(out_sig_b),
    .out_chan(out_chan)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int sre [NLTA][NCH][NSIG][TLEN];
  int sim [NLTA][NCH][NSIG][TLEN];
  int q_re[$], q_im[$], q_a[$], q_b[$], q_c[$];
  bit bp_en = 0;
  bit hold_pend = 0;
  int h_re, h_im, h_a, h_b;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // output side: random ready, hold check (R8), capture
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend)
        check(out_valid && int'(out_re) == h_re && int'(out_im) == h_im &&
              int'(out_sig_a) == h_a && int'(out_sig_b) == h_b,
              "R8", "stalled result changed", int'(out_re), h_re);
      out_ready = bp_en ? ($urandom_range(0, 1) == 1) : 1'b1;
      #1;
      if (out_valid && out_ready) begin
        q_re.push_back(int'(out_re)); q_im.push_back(int'(out_im));
        q_a.push_back(int'(out_sig_a)); q_b.push_back(int'(out_sig_b));
        q_c.push_back(int'(out_chan));
      end
      hold_pend = out_valid && !out_ready;
      h_re = int'(out_re); h_im = int'(out_im); h_a = int'(out_sig_a); h_b = int'(out_sig_b);
    end
  end

  task automatic gen(input int mode);
    for (int f = 0; f < NLTA; f++)
      for (int c = 0; c < NCH; c++)
        for (int s = 0; s < NSIG; s++)
          for (int t = 0; t < TLEN; t++) begin
            sre[f][c][s][t] = (mode == 1) ? -8 : $urandom_range(0, 15) - 8;
            sim[f][c][s][t] = (mode == 1) ? -8 : $urandom_range(0, 15) - 8;
          end
  endtask

  task automatic feed_frame(input int f, input bit gap);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      for (int s = 0; s < NSIG; s++)
        for (int t = 0; t < TLEN; t++) begin
          if (gap)
            while ($urandom_range(0, 2) == 0) begin in_valid = 1'b0; @(negedge clk); end
          in_valid = 1'b1;
          in_re = sre[f][c][s][t][SW-1:0];
          in_im = sim[f][c][s][t][SW-1:0];
          while (!in_ready) @(negedge clk);
          @(negedge clk);
        end
      in_valid = 1'b0;
      check(!in_ready, "R1", "in_ready after channel load", int'(in_ready), 0);
    end
  endtask

  task automatic run_long(input int mode, input bit gap, input bit bp, input string req);
    int want, idx, er, ei, i, j;
    gen(mode);
    bp_en = bp;
    q_re.delete(); q_im.delete(); q_a.delete(); q_b.delete(); q_c.delete();
    for (int f = 0; f < NLTA; f++) begin
      feed_frame(f, gap);
      if (f == NLTA - 2) begin
        repeat (200) @(negedge clk);
        check(q_re.size() == 0, "R6", "results before final short integration", q_re.size(), 0);
      end
    end
    want = NCH * NPAIR;
    for (int k = 0; k < 20000 && q_re.size() < want; k++) @(negedge clk);
    repeat (40) @(negedge clk);
    check(q_re.size() == want, "R4", "result count", q_re.size(), want);
    idx = 0;
    for (int c = 0; c < NCH; c++)
      for (int ti = 0; ti < NT; ti++)
        for (int tj = ti; tj < NT; tj++)
          for (int r = 0; r < ARR; r++)
            for (int cc = 0; cc < ARR; cc++) begin
              i = ti * ARR + r; j = tj * ARR + cc;
              if (i <= j && idx < q_re.size()) begin
                er = 0; ei = 0;
                for (int f = 0; f < NLTA; f++)
                  for (int t = 0; t < TLEN; t++) begin
                    er += sre[f][c][i][t] * sre[f][c][j][t] + sim[f][c][i][t] * sim[f][c][j][t];
                    ei += sim[f][c][i][t] * sre[f][c][j][t] - sre[f][c][i][t] * sim[f][c][j][t];
                  end
                check(q_c[idx] == c && q_a[idx] == i && q_b[idx] == j, "R5", "pair/channel order",
                      q_a[idx] * 100 + q_b[idx], i * 100 + j);
                check(q_re[idx] == er, req, "real sum", q_re[idx], er);
                check(q_im[idx] == ei, req, "imag sum", q_im[idx], ei);
                idx++;
              end
            end
    bp_en = 0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!out_valid, "R9", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready, "R9", "in_ready after reset", int'(in_ready), 1);
    check(!out_valid, "R9", "out_valid after reset", int'(out_valid), 0);
  endtask

  task automatic t_random;      run_long(0, 1'b0, 1'b0, "R2"); endtask
  task automatic t_clear;       run_long(0, 1'b0, 1'b0, "R7"); endtask
  task automatic t_extreme;     run_long(1, 1'b0, 1'b0, "R3"); endtask
  task automatic t_backpressure; run_long(0, 1'b1, 1'b1, "R2"); endtask

  initial begin
    t_reset();
    t_random();
    t_clear();
    t_extreme();
    t_backpressure();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule